// File: doc/BRIEF.md
# Programmable Counter Array

A free-running 16-bit up-counter shared by a set of compare/capture channels (two by default). Software programs the block through a byte-wide register port with a separate combinational read port. The counter advances once per clock in which the `tick` strobe is high and the run bit is set. It can be paused while the system is idle, and it raises an overflow flag when it wraps.

Each channel has a 7-bit mode register, a 16-bit compare/capture register made of a low byte and a high byte, an input pin, an output pin and a flag. The channel's state is a small machine loaded by every write to its mode register. The states are:

- CH_OFF: the channel does nothing.
- CH_CAPTURE: the channel latches the count on selected pin edges.
- CH_TIMER: the channel flags a 16-bit match.
- CH_TOGGLE: the channel flags a match and inverts its output on each match.
- CH_PWM: the channel drives an 8-bit pulse-width level and reloads its duty byte at each low-byte rollover.

Every transition is a "mode write". The decode priority is PWM, then toggle, then timer, then capture, then off.

Register map (byte addresses):

| Address | Register |
|---|---|
| 0 | config: bit 7 stop-in-idle, bit 0 overflow interrupt enable |
| 1 | control: bit 7 overflow flag, bit 6 run, bit n flag of channel n |
| 2 | count low byte |
| 3 | count high byte |
| 4+4n | mode of channel n |
| 5+4n | capture/compare low byte of channel n |
| 6+4n | capture/compare high byte of channel n |

Mode bits: 0 compare enable, 1 rising-edge capture, 2 falling-edge capture, 3 match, 4 toggle, 5 PWM, 6 interrupt enable.

Top module: `pca_unit`

## Requirements
- R1: After reset every register reads 0, both output pins are 0 and `irq` is 0.
- R2: The count increments by one on a clock edge only when control bit 6 (run) is 1 and `tick` is 1; otherwise it holds unless software writes address 2 or 3.
- R3: A step from FFFFh to 0000h sets control bit 7. A write to address 1 loads the flags, but a hardware flag set in the same cycle wins over a written 0.
- R4: With config bit 7 set, the count holds while `idle` is 1. With the bit clear, `idle` has no effect.
- R5: In capture state, mode bit 1 selects rising edges and mode bit 2 selects falling edges of the channel's input pin. On a selected edge the current count is latched into the capture register and the channel flag is set at that same clock edge. An edge that is not selected changes nothing.
- R6: In timer state (mode 09h), the channel flag is set at the clock edge where the count steps onto the 16-bit compare value, and not one step earlier.
- R7: In toggle state (mode 11h), the output pin inverts each time the count steps onto the compare value.
- R8: In PWM state (mode 21h), the output pin is 0 while the count low byte is below the duty low byte and 1 otherwise, so one 256-step period holds 256 minus the duty value high levels.
- R9: In PWM state, the duty high byte is copied into the duty low byte only when the count low byte rolls from FFh to 00h. A write to the high byte leaves the low byte unchanged until then.
- R10: `irq` is 1 when the overflow flag and config bit 0 are both set, or when any channel's flag and its mode bit 6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count strobe |
| idle | input | 1 | System idle indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address |
| reg_wdata | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cex_in | input | 2 | Channel input pins |
| cex_out | output | 2 | Channel output pins |
| irq | output | 1 | Interrupt request |

## Verification
A software write to the control register and a hardware flag set can land on the same clock edge. The bench provokes this by driving a write that clears all flags in the very cycle whose `tick` steps the count onto a timer channel's compare value. The control register must then still show that channel's flag set. A second overlap, the duty reload coinciding with a fresh write of the duty high byte, is judged by reading the low byte before and after the rollover and by counting high levels over consecutive PWM periods.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int MODE_W    = 7;
    localparam int MB_CMP    = 0;
    localparam int MB_RISE   = 1;
    localparam int MB_FALL   = 2;
    localparam int MB_MATCH  = 3;
    localparam int MB_TOGGLE = 4;
    localparam int MB_PWM    = 5;
    localparam int MB_IRQ    = 6;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_CAPTURE,
        CH_TIMER,
        CH_TOGGLE,
        CH_PWM
    } ch_state_e;

    // priority: pwm, toggle, timer, capture, off
    function automatic ch_state_e decode_mode(input logic [MODE_W-1:0] m);
        if (m[MB_CMP] && m[MB_PWM])         return CH_PWM;
        else if (m[MB_CMP] && m[MB_TOGGLE]) return CH_TOGGLE;
        else if (m[MB_CMP] && m[MB_MATCH])  return CH_TIMER;
        else if (m[MB_RISE] || m[MB_FALL])  return CH_CAPTURE;
        else                                return CH_OFF;
    endfunction

endpackage

// File: rtl/pca_timebase.sv
module pca_timebase #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              idle,
    input  logic              cfg_wr,
    input  logic              ctl_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic              inc,
    output logic              run_q,
    output logic              ovf_q,
    output logic              stop_idle_q,
    output logic              ovf_ie_q
);

    logic step;
    logic sw_cnt;
    logic wrap;

    always_comb begin
        step   = run_q && tick && !(idle && stop_idle_q);
        sw_cnt = lo_wr || hi_wr;
        inc    = step && !sw_cnt;
        cnt_nx = cnt_q + 1'b1;
        wrap   = inc && (cnt_q == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_cnt) begin
            if (lo_wr) cnt_q[BYTE_W-1:0]     <= wdata;
            if (hi_wr) cnt_q[CNT_W-1:BYTE_W] <= wdata;
        end else if (inc) begin
            cnt_q <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            ovf_q       <= 1'b0;
            stop_idle_q <= 1'b0;
            ovf_ie_q    <= 1'b0;
        end else begin
            if (cfg_wr) begin
                stop_idle_q <= wdata[BYTE_W-1];
                ovf_ie_q    <= wdata[0];
            end
            if (ctl_wr) begin
                run_q <= wdata[BYTE_W-2];
                ovf_q <= wdata[BYTE_W-1];
            end
            if (wrap) ovf_q <= 1'b1;
        end
    end

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !lo_wr && !hi_wr) |=> $stable(cnt_q)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && stop_idle_q && !lo_wr && !hi_wr) |=> $stable(cnt_q)); // R4

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == '1) |=> (ovf_q && cnt_q == '0)); // R3

endmodule

// File: rtl/pca_channel.sv
module pca_channel
    import pca_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  cnt_nx,
    input  logic              inc,
    input  logic              mode_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              flag_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_wdata,
    input  logic              pin_in,
    output logic [MODE_W-1:0] mode_q,
    output logic [CNT_W-1:0]  cap_q,
    output logic              flag_q,
    output logic              pin_out,
    output logic              irq_req
);

    ch_state_e state_q;
    logic      pin_prev;
    logic      hso_q;
    logic      hit;
    logic      cap_evt;
    logic      match_evt;
    logic      flip;
    logic      roll;
    logic      pwm_lvl;

    // state register: every mode write is a transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            mode_q  <= '0;
        end else if (mode_wr) begin
            state_q <= decode_mode(wdata[MODE_W-1:0]);
            mode_q  <= wdata[MODE_W-1:0];
        end
    end

    // outputs of the state machine
    always_comb begin
        hit       = inc && (cnt_nx == cap_q);
        pwm_lvl   = (cnt_q[BYTE_W-1:0] >= cap_q[BYTE_W-1:0]);
        cap_evt   = 1'b0;
        match_evt = 1'b0;
        flip      = 1'b0;
        roll      = 1'b0;
        pin_out   = hso_q;
        unique case (state_q)
            CH_OFF: ;
            CH_CAPTURE: begin
                cap_evt = (mode_q[MB_RISE] && pin_in && !pin_prev) ||
                          (mode_q[MB_FALL] && !pin_in && pin_prev);
            end
            CH_TIMER: begin
                match_evt = hit;
            end
            CH_TOGGLE: begin
                match_evt = hit;
                flip      = hit;
            end
            CH_PWM: begin
                roll    = inc && (cnt_q[BYTE_W-1:0] == '1);
                pin_out = pwm_lvl;
            end
            default: ;
        endcase
        irq_req = flag_q && mode_q[MB_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
            hso_q    <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            pin_prev <= pin_in;
            if (flip) hso_q <= !hso_q;
            if (flag_wr) flag_q <= flag_wdata;
            if (cap_evt || match_evt) flag_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_evt) begin
            cap_q <= cnt_q;
        end else begin
            if (roll)       cap_q[BYTE_W-1:0] <= cap_q[CNT_W-1:BYTE_W];
            else if (lo_wr) cap_q[BYTE_W-1:0] <= wdata;
            if (hi_wr)      cap_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (flag_q && cap_q == $past(cnt_q))); // R5

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_TIMER && inc && cnt_nx == cap_q) |=> flag_q); // R6

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_TOGGLE && hit) |=> (hso_q != $past(hso_q))); // R7

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PWM && !inc && !lo_wr) |=> $stable(cap_q[BYTE_W-1:0])); // R9

endmodule

// File: rtl/pca_unit.sv
module pca_unit
    import pca_pkg::*;
#(
    parameter int NUM_MOD = 2,
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               idle,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic [NUM_MOD-1:0] cex_in,
    output logic [NUM_MOD-1:0] cex_out,
    output logic               irq
);

    localparam int CNT_W     = 2 * BYTE_W;
    localparam int A_CFG     = 0;
    localparam int A_CTL     = 1;
    localparam int A_CLO     = 2;
    localparam int A_CHI     = 3;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int OFF_MODE  = 0;
    localparam int OFF_LO    = 1;
    localparam int OFF_HI    = 2;

    function automatic logic [ADDR_W-1:0] ch_addr(input int idx, input int off);
        return ADDR_W'(CH_BASE + idx * CH_STRIDE + off);
    endfunction

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nx;
    logic               inc;
    logic               run_q;
    logic               ovf_q;
    logic               stop_idle_q;
    logic               ovf_ie_q;
    logic               ctl_wr;

    logic [MODE_W-1:0]  mode_a [NUM_MOD];
    logic [CNT_W-1:0]   cap_a  [NUM_MOD];
    logic [NUM_MOD-1:0] flag_v;
    logic [NUM_MOD-1:0] irq_v;

    assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTL));

    pca_timebase #(.BYTE_W(BYTE_W)) i_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .idle        (idle),
        .cfg_wr      (reg_wr && (reg_addr == ADDR_W'(A_CFG))),
        .ctl_wr      (ctl_wr),
        .lo_wr       (reg_wr && (reg_addr == ADDR_W'(A_CLO))),
        .hi_wr       (reg_wr && (reg_addr == ADDR_W'(A_CHI))),
        .wdata       (reg_wdata),
        .cnt_q       (cnt_q),
        .cnt_nx      (cnt_nx),
        .inc         (inc),
        .run_q       (run_q),
        .ovf_q       (ovf_q),
        .stop_idle_q (stop_idle_q),
        .ovf_ie_q    (ovf_ie_q)
    );

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_ch
        pca_channel #(.BYTE_W(BYTE_W)) i_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_q      (cnt_q),
            .cnt_nx     (cnt_nx),
            .inc        (inc),
            .mode_wr    (reg_wr && (reg_addr == ch_addr(g, OFF_MODE))),
            .lo_wr      (reg_wr && (reg_addr == ch_addr(g, OFF_LO))),
            .hi_wr      (reg_wr && (reg_addr == ch_addr(g, OFF_HI))),
            .flag_wr    (ctl_wr),
            .wdata      (reg_wdata),
            .flag_wdata (reg_wdata[g]),
            .pin_in     (cex_in[g]),
            .mode_q     (mode_a[g]),
            .cap_q      (cap_a[g]),
            .flag_q     (flag_v[g]),
            .pin_out    (cex_out[g]),
            .irq_req    (irq_v[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CFG)) begin
            rd_data[BYTE_W-1] = stop_idle_q;
            rd_data[0]        = ovf_ie_q;
        end else if (rd_addr == ADDR_W'(A_CTL)) begin
            rd_data[BYTE_W-1]    = ovf_q;
            rd_data[BYTE_W-2]    = run_q;
            rd_data[NUM_MOD-1:0] = flag_v;
        end else if (rd_addr == ADDR_W'(A_CLO)) begin
            rd_data = cnt_q[BYTE_W-1:0];
        end else if (rd_addr == ADDR_W'(A_CHI)) begin
            rd_data = cnt_q[CNT_W-1:BYTE_W];
        end
        for (int i = 0; i < NUM_MOD; i++) begin
            if (rd_addr == ch_addr(i, OFF_MODE)) rd_data = BYTE_W'(mode_a[i]);
            if (rd_addr == ch_addr(i, OFF_LO))   rd_data = cap_a[i][BYTE_W-1:0];
            if (rd_addr == ch_addr(i, OFF_HI))   rd_data = cap_a[i][CNT_W-1:BYTE_W];
        end
    end

    assign irq = (ovf_q && ovf_ie_q) || (|irq_v);

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ovf_q && ovf_ie_q) || (|(flag_v & irq_v)))); // R10

endmodule

// File: tb/test_pca_unit.sv
module test_pca_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       idle = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] cex_in = '0;
    logic [1:0] cex_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;   // 0 register, 1 pin, 2 irq, 3 measured value
        int    addr;
        int    actual;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];

    always #4 clk = !clk;

    pca_unit i_pca_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .idle      (idle),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cex_in    (cex_in),
        .cex_out   (cex_out),
        .irq       (irq)
    );

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            item_t it;
            int act;
            wait (sb.size() > 0);
            it = sb[0];
            if (it.kind == 0) rd_addr = 4'(it.addr);
            #1;
            case (it.kind)
                0:       act = int'(rd_data);
                1:       act = int'(cex_out[it.addr]);
                2:       act = int'(irq);
                default: act = it.actual;
            endcase
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s kind %0d addr %0d: actual %0h expected %0h",
                         it.req, it.kind, it.addr, act, it.exp);
            end
            void'(sb.pop_front());
        end
    end

    task automatic push(input int kind, input int addr, input int actual,
                        input int exp, input string req);
        item_t it;
        it.kind = kind; it.addr = addr; it.actual = actual;
        it.exp = exp; it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic chk_reg(input int a, input int e, input string r);
        push(0, a, 0, e, r);
    endtask

    task automatic chk_pin(input int p, input int e, input string r);
        push(1, p, 0, e, r);
    endtask

    task automatic chk_irq(input int e, input string r);
        push(2, 0, 0, e, r);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_tick(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d); tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic measure(output int hi);
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < 256; i++) begin
            if (cex_out[0]) hi++;
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg(1, 8'h00, "R1"); chk_reg(2, 8'h00, "R1"); chk_reg(3, 8'h00, "R1");
        chk_reg(4, 8'h00, "R1"); chk_reg(9, 8'h00, "R1"); chk_reg(0, 8'h00, "R1");
        chk_pin(0, 0, "R1"); chk_pin(1, 0, "R1"); chk_irq(0, "R1");

        // R2 run and tick gating
        wr(3, 8'hFF); wr(2, 8'hFE); wr(1, 8'h40);
        repeat (3) @(negedge clk);
        chk_reg(2, 8'hFE, "R2");
        ticks(1);
        chk_reg(2, 8'hFF, "R2"); chk_reg(3, 8'hFF, "R2"); chk_reg(1, 8'h40, "R3");
        // R3 wrap sets the overflow flag
        ticks(1);
        chk_reg(2, 8'h00, "R3"); chk_reg(3, 8'h00, "R3"); chk_reg(1, 8'hC0, "R3");
        // R10 overflow interrupt
        wr(0, 8'h01);
        chk_irq(1, "R10");
        wr(1, 8'h40);
        chk_reg(1, 8'h40, "R3"); chk_irq(0, "R10");

        // R4 stop in idle
        wr(0, 8'h80); idle = 1'b1;
        ticks(5);
        chk_reg(2, 8'h00, "R4");
        wr(0, 8'h00);
        ticks(5);
        chk_reg(2, 8'h05, "R4");
        idle = 1'b0;

        // R5 capture on selected edges
        wr(1, 8'h00); wr(3, 8'h12); wr(2, 8'h34); wr(4, 8'h02);
        cex_in[0] = 1'b1; @(negedge clk);
        chk_reg(5, 8'h34, "R5"); chk_reg(6, 8'h12, "R5"); chk_reg(1, 8'h01, "R5");
        wr(1, 8'h00); wr(2, 8'h78); wr(3, 8'h56);
        cex_in[0] = 1'b0; @(negedge clk);
        chk_reg(5, 8'h34, "R5"); chk_reg(1, 8'h00, "R5");
        wr(4, 8'h04);
        cex_in[0] = 1'b1; @(negedge clk);
        chk_reg(1, 8'h00, "R5");
        cex_in[0] = 1'b0; @(negedge clk);
        chk_reg(5, 8'h78, "R5"); chk_reg(6, 8'h56, "R5"); chk_reg(1, 8'h01, "R5");
        wr(1, 8'h00); wr(4, 8'h06); wr(2, 8'h9A);
        cex_in[0] = 1'b1; @(negedge clk);
        chk_reg(5, 8'h9A, "R5");
        wr(4, 8'h00); wr(1, 8'h00);

        // R6 software timer match
        wr(3, 8'h00); wr(2, 8'h00);
        wr(8, 8'h09); wr(9, 8'h10); wr(10, 8'h00); wr(1, 8'h40);
        ticks(15);
        chk_reg(2, 8'h0F, "R6"); chk_reg(1, 8'h40, "R6");
        ticks(1);
        chk_reg(2, 8'h10, "R6"); chk_reg(1, 8'h42, "R6");
        wr(8, 8'h49);
        chk_irq(1, "R10");
        wr(1, 8'h40);
        chk_irq(0, "R10");

        // R3 flag set and clearing write in the same cycle
        wr(9, 8'h11);
        wr_tick(1, 8'h40);
        chk_reg(2, 8'h11, "R3"); chk_reg(1, 8'h42, "R3");
        wr(8, 8'h00); wr(1, 8'h40);

        // R7 toggle on match
        wr(8, 8'h11); wr(9, 8'h14); wr(2, 8'h00);
        ticks(19);
        chk_pin(1, 0, "R7");
        ticks(1);
        chk_pin(1, 1, "R7");
        wr(2, 8'h00);
        ticks(20);
        chk_pin(1, 0, "R7");
        wr(8, 8'h00);

        // R8 / R9 PWM duty and reload
        wr(4, 8'h21); wr(6, 8'h40); wr(5, 8'h40); wr(3, 8'h00); wr(2, 8'h00);
        chk_pin(0, 0, "R8");
        measure(hi); push(3, 0, hi, 192, "R8");
        wr(6, 8'hC0);
        chk_reg(5, 8'h40, "R9");
        measure(hi); push(3, 0, hi, 192, "R9");
        chk_reg(5, 8'hC0, "R9");
        chk_pin(0, 0, "R8");
        measure(hi); push(3, 0, hi, 64, "R8");
        wr(6, 8'h00);
        measure(hi); push(3, 0, hi, 64, "R9");
        measure(hi); push(3, 0, hi, 256, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule